// File: doc/BRIEF.md
# Saturating Odd-Length Frame Statistics Counter

This block keeps a running tally of received frames whose length is not a whole number of bytes. The receive logic flags each such frame with a one-cycle pulse on `evt_i`. The block adds one to a 16-bit count for each pulse. At its maximum value the count stays put and does not roll over to zero.

Software reaches the count through a simple register port. That port has an address, a read strobe, a write strobe, write data and registered read data. The count is held in the low half of a 32-bit word, and the upper half always reads as zero.

The clearing policy is chosen by `clr_mode_i`:
- In read-clear mode, every read of the register returns the value and zeroes the count.
- In key-clear mode, reads leave the count alone. Only a write of the key word 0x11111111 zeroes it.

Top module: `frame_err_stat_ctr`

## Requirements
- R1: Each cycle with `evt_i` high, and no clear in that cycle, raises the count by exactly one, as long as the count is below 0xFFFF.
- R2: Once the count is 0xFFFF, further events are ignored and the count stays at 0xFFFF until it is cleared.
- R3: With `clr_mode_i` = 1, a read of the register (`rd_i` high, `addr_i` = `REG_ADDR`) returns the current count and leaves the count at 0 in the next cycle.
- R4: With `clr_mode_i` = 0, a write of exactly 0x11111111 to the register leaves the count at 0 in the next cycle.
- R5: With `clr_mode_i` = 0, a write of any value other than 0x11111111 leaves the count unchanged. With `clr_mode_i` = 1, writes of any value leave the count unchanged.
- R6: With `clr_mode_i` = 0, reads do not change the count.
- R7: Bits 31:16 of `rdata_o` are always 0, and the count appears in bits 15:0.
- R8: After reset, the count is 0 and `rdata_o` is 0.
- R9: When a clearing access and an event occur in the same cycle, the clear wins and the count becomes 0.
- R10: `rdata_o` is registered and appears one cycle after the read strobe. It holds the count from before any clear that the same read causes. In every cycle that follows no register read, `rdata_o` is 0.
- R11: An access whose `addr_i` is not `REG_ADDR` neither clears nor returns the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_mode_i | input | 1 | 1 = clear on read, 0 = clear by key write |
| evt_i | input | 1 | One-cycle pulse for each odd-length frame |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The bench runs more than 65,535 events and then reads the count, to catch a counter that wraps to zero or stops one short of 0xFFFF.

It issues reads that land in the same cycle as an event, in read-clear mode. A design that let the event win there would leave the count at 1. A design that returned the value after the clear would read back 0.

Key writes are mixed with near-miss values that differ from the key in a single bit. They are also mixed with reads in key mode and writes in read mode. A design that decodes the key loosely, or that applies a clear in the wrong mode, loses counts that the bench model keeps.

Random traffic to other addresses exposes a decode that ignores the address.

// File: rtl/stat_pkg.sv
package stat_pkg;
  typedef enum logic {
    CLR_BY_KEY  = 1'b0,
    CLR_BY_READ = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/stat_bus_dec.sv
module stat_bus_dec
  import stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [DATA_W-1:0] CLR_KEY = '0
) (
  input  logic              clr_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_hit_o,
  output logic              clr_o
);
  clr_mode_e mode;
  logic      hit;

  always_comb begin
    mode     = clr_mode_e'(clr_mode_i);
    hit      = (addr_i == REG_ADDR);
    rd_hit_o = rd_i && hit;
    unique case (mode)
      CLR_BY_READ: clr_o = rd_i && hit;
      CLR_BY_KEY:  clr_o = wr_i && hit && (wdata_i == CLR_KEY);
      default:     clr_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/stat_sat_cnt.sv
module stat_sat_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;  // clear beats a same-cycle event
    else if (evt_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !clr_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  p_sat_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);
  p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/stat_rd_port.sv
module stat_rd_port #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_hit_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd_hit_i) rdata_o <= {{PAD_W{1'b0}}, cnt_i};  // pre-clear value
    else               rdata_o <= '0;
  end

  p_rd_value_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_i |=> rdata_o[CNT_W-1:0] == $past(cnt_i));
  p_rd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit_i |=> rdata_o == '0);
endmodule

// File: rtl/frame_err_stat_ctr.sv
module frame_err_stat_ctr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h30,
  parameter logic [DATA_W-1:0] CLR_KEY  = 32'h1111_1111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_mode_i,
  input  logic              evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic             rd_hit;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  stat_bus_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .CLR_KEY(CLR_KEY)
  ) u_dec (
    .clr_mode_i(clr_mode_i), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_hit_o(rd_hit), .clr_o(clr)
  );

  stat_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_i(clr), .cnt_o(cnt)
  );

  stat_rd_port #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_hit_i(rd_hit), .cnt_i(cnt),
    .rdata_o(rdata_o)
  );

  p_rd_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mode_i && rd_i && addr_i == REG_ADDR) |=> cnt == '0);
  p_key_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_mode_i && wr_i && addr_i == REG_ADDR && wdata_i == CLR_KEY) |=> cnt == '0);
  p_key_rd_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_mode_i && !evt_i && !(wr_i && wdata_i == CLR_KEY)) |=> $stable(cnt));
  p_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:CNT_W] == '0);
  p_miss_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != REG_ADDR && !evt_i) |=> $stable(cnt));
endmodule

// File: tb/frame_err_stat_ctr_test.sv
module frame_err_stat_ctr_test;
  localparam logic [7:0]  ADDR = 8'h30;
  localparam logic [31:0] KEY  = 32'h1111_1111;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_mode_i = 1'b0;
  logic        evt_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model = '0;

  always #5ns clk_i = ~clk_i;

  frame_err_stat_ctr uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_mode_i(clr_mode_i), .evt_i(evt_i),
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  function automatic logic [31:0] exp_rd(logic r, logic [7:0] a, logic [15:0] c);
    return (r && a == ADDR) ? {16'h0, c} : 32'h0;
  endfunction

  function automatic logic [15:0] exp_next(logic e, logic r, logic w, logic m,
                                           logic [7:0] a, logic [31:0] d,
                                           logic [15:0] c);
    logic clr;
    clr = (a == ADDR) && ((m && r) || (!m && w && d == KEY));
    if (clr) return 16'h0;
    if (e && c != 16'hFFFF) return c + 16'd1;
    return c;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata_o=%h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, then check read data at the following negedge
  task automatic step(logic e, logic r, logic w, logic m, logic [7:0] a,
                      logic [31:0] d, string tag, bit chk = 1'b1);
    logic [31:0] er;
    evt_i = e; rd_i = r; wr_i = w; clr_mode_i = m; addr_i = a; wdata_i = d;
    er = exp_rd(r, a, model);
    model = exp_next(e, r, w, m, a, d, model);
    @(negedge clk_i);
    if (chk) check(rdata_o, er, tag);
    evt_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic peek(string tag);
    step(1'b0, 1'b1, 1'b0, 1'b0, ADDR, 32'h0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1.5ms;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk_i);
    check(rdata_o, 32'h0, "R8 rdata in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    peek("R8 count after reset");

    // R1: counting
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, ADDR, 32'h0, "R1 evt");
    peek("R1 five events");
    // R6: reads in key mode keep the value
    peek("R6 repeated read");
    // R5: near-miss key and read-mode writes
    step(1'b0, 1'b0, 1'b1, 1'b0, ADDR, KEY ^ 32'h0001_0000, "R5 near key");
    step(1'b0, 1'b0, 1'b1, 1'b1, ADDR, KEY, "R5 write in read mode");
    peek("R5 count kept");
    // R11: wrong address
    step(1'b0, 1'b0, 1'b1, 1'b0, ADDR ^ 8'h01, KEY, "R11 key to other addr");
    step(1'b0, 1'b1, 1'b0, 1'b1, ADDR ^ 8'h04, 32'h0, "R11 read other addr");
    peek("R11 count kept");
    // R4 and R9: key write with an event
    step(1'b1, 1'b0, 1'b1, 1'b0, ADDR, KEY, "R9 key clear with evt");
    peek("R4 cleared by key");
    // R3, R9, R10: read-clear with an event, value before clear
    step(1'b1, 1'b0, 1'b0, 1'b1, ADDR, 32'h0, "R1 evt");
    step(1'b1, 1'b1, 1'b0, 1'b1, ADDR, 32'h0, "R10 pre-clear value");
    peek("R3 cleared by read");

    // R2: saturation
    for (int i = 0; i < 65540; i++)
      step(1'b1, 1'b0, 1'b0, 1'b0, ADDR, 32'h0, "R2 evt", 1'b0);
    peek("R2 saturated");
    step(1'b1, 1'b0, 1'b0, 1'b0, ADDR, 32'h0, "R2 evt at max");
    peek("R2 still saturated");
    step(1'b0, 1'b1, 1'b0, 1'b1, ADDR, 32'h0, "R3 read max then clear");
    peek("R3 zero after read clear");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic        e, r, w, m;
      logic [7:0]  a;
      logic [31:0] d;
      int          sel;
      e = ($urandom % 3) != 0;
      r = ($urandom % 4) == 0;
      w = ($urandom % 6) == 0;
      m = ($urandom % 8) == 0;
      a = (($urandom % 5) == 0) ? 8'($urandom) : ADDR;
      sel = $urandom % 4;
      d = (sel == 0) ? KEY : (sel == 1) ? (KEY ^ (32'h1 << ($urandom % 32))) : $urandom;
      step(e, r, w, m, a, d, "R1 R3 R4 R5 R7 R9 R11 random");
    end
    peek("R7 final readback");
    finish_run();
  end
endmodule